// File: doc/BRIEF.md
# Comparator Edge Interrupt and Control Register

This block is the digital side of an analog voltage comparator. It brings the comparator's raw decision bit into the clock domain through a synchronizer and shows the result as a read-only status bit. Software chooses which edge of that result should raise an interrupt: rising, falling or either direction. It can also route the result to a timer as an input-capture trigger.

Two 8-bit registers sit behind a small read/write port. The main register (address 0) holds the power-down bit, the reference select, the status bit, the interrupt flag, the interrupt enable, the capture-route enable and the two edge-mode bits. The auxiliary register (address 1) holds, in bit 0, the request to let the converter's multiplexer drive the comparator's negative input. That request only takes effect while the converter is off. The analog comparator, the reference and the multiplexer stay outside this block. Its outputs only steer them.

Top module: `cmp_ctrl_top`

## Requirements
- R1: After reset both registers read 0x00, `irq` is 0 and `cmp_off`, `ref_sel`, `neg_from_mux` and `cap_trig` are 0.
- R2: Main register bit 5 reads the comparator result through a two-flop synchronizer: a change of `cmp_raw` is visible two clock edges later. Writes to bit 5 have no effect.
- R3: Main register bits 7, 6, 3, 2, 1, 0 and auxiliary bit 0 read back what was written. Auxiliary bits 7..1 read 0.
- R4: Mode bits [1:0]=11 set the flag (bit 4) on a rising status edge only. Mode 10 sets it on a falling edge only. The flag is set on the clock edge after the status bit changes.
- R5: Mode 00 sets the flag on either edge. Mode 01 never sets it.
- R6: The flag is cleared by writing 1 to bit 4 of the main register or by an `irq_ack` pulse. Writing 0 to bit 4 leaves it unchanged. A new edge in the same cycle as a clear wins.
- R7: `irq` is high exactly when the flag and the interrupt enable (bit 3) are both set.
- R8: While bit 7 (power-down) is 1, `cmp_off` is 1, the status bit reads 0 and no edge sets the flag.
- R9: `neg_from_mux` is 1 exactly when auxiliary bit 0 is 1 and `adc_on` is 0.
- R10: `cap_trig` equals the status bit when bit 2 is 1, and is 0 otherwise.
- R11: `ref_sel` follows bit 6 of the main register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | 0 = main register, 1 = auxiliary register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| cmp_raw | input | 1 | Raw comparator decision, asynchronous |
| adc_on | input | 1 | Converter enabled |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| cmp_off | output | 1 | Power down the comparator |
| ref_sel | output | 1 | Use the internal reference on the positive input |
| neg_from_mux | output | 1 | Converter multiplexer drives the negative input |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | Timer input-capture trigger |

## Verification
The assertions assume that `cmp_raw` changes at most once per clock. They also assume that `irq_ack` and a write of 1 to the flag bit are the only ways the flag is cleared, so any cycle with a detected edge must see the flag set one edge later. The bench changes `cmp_raw`, `irq_ack` and the register port only on falling clock edges. Between level changes it holds `cmp_raw` steady for several clocks, so each change gives the synchronizer and edge detector one clean transition. It waits for that transition to settle before it changes the mode or clears the flag.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
    localparam int REG_W    = 8;
    localparam int SYNC_LEN = 2;

    localparam int BIT_OFF  = 7;
    localparam int BIT_REF  = 6;
    localparam int BIT_STAT = 5;
    localparam int BIT_FLAG = 4;
    localparam int BIT_IE   = 3;
    localparam int BIT_CAP  = 2;
    localparam int BIT_AUX_MUX = 0;

    typedef enum logic [1:0] {
        EDGE_ANY  = 2'b00,
        EDGE_NONE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_RISE = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic       off;
        logic       ref_sel;
        logic       flag;
        logic       ie;
        logic       cap_en;
        edge_mode_e mode;
        logic       mux_en;
    } ctrl_regs_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        if (clr) sync_d = '0;
        else     sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/cmp_edge.sv
module cmp_edge
    import cmp_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       enable,
    input  edge_mode_e mode,
    output logic       hit
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = enable ? level : 1'b0;
        rise   = level & ~prev_q;
        fall   = ~level & prev_q;
        unique case (mode)
            EDGE_ANY:  hit = rise | fall;
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            default:   hit = 1'b0;
        endcase
        if (!enable) hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    AST_NONE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_NONE) |-> !hit); // R5
endmodule

// File: rtl/cmp_ctrl_top.sv
module cmp_ctrl_top
    import cmp_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmp_raw,
    input  logic             adc_on,
    input  logic             irq_ack,
    output logic             cmp_off,
    output logic             ref_sel,
    output logic             neg_from_mux,
    output logic             irq,
    output logic             cap_trig
);
    ctrl_regs_t regs_d, regs_q;
    logic       status;
    logic       hit;
    logic       wr_main, wr_aux;

    cmp_sync #(.STAGES(SYNC_LEN)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (regs_q.off),
        .din  (cmp_raw),
        .dout (status)
    );

    cmp_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (status),
        .enable(~regs_q.off),
        .mode  (regs_q.mode),
        .hit   (hit)
    );

    always_comb begin
        wr_main = reg_we & ~reg_addr;
        wr_aux  = reg_we &  reg_addr;
        regs_d  = regs_q;
        if (wr_main) begin
            regs_d.off     = reg_wdata[BIT_OFF];
            regs_d.ref_sel = reg_wdata[BIT_REF];
            regs_d.ie      = reg_wdata[BIT_IE];
            regs_d.cap_en  = reg_wdata[BIT_CAP];
            regs_d.mode    = edge_mode_e'(reg_wdata[1:0]);
            if (reg_wdata[BIT_FLAG]) regs_d.flag = 1'b0;
        end
        if (wr_aux) regs_d.mux_en = reg_wdata[BIT_AUX_MUX];
        if (irq_ack) regs_d.flag = 1'b0;
        if (hit)     regs_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (reg_addr) begin
            reg_rdata = '0;
            reg_rdata[BIT_AUX_MUX] = regs_q.mux_en;
        end else begin
            reg_rdata = {regs_q.off, regs_q.ref_sel, status, regs_q.flag,
                         regs_q.ie, regs_q.cap_en, regs_q.mode};
        end
    end

    assign cmp_off      = regs_q.off;
    assign ref_sel      = regs_q.ref_sel;
    assign neg_from_mux = regs_q.mux_en & ~adc_on;
    assign irq          = regs_q.flag & regs_q.ie;
    assign cap_trig     = regs_q.cap_en & status;

    AST_OFF_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.off |=> !status); // R8
    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> regs_q.flag); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !hit) |=> !regs_q.flag); // R6
    AST_RISE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status) && regs_q.mode == EDGE_RISE && !regs_q.off) |=> regs_q.flag); // R4
    AST_FLAG_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.flag && !hit) |=> !regs_q.flag); // R5
endmodule

// File: tb/cmp_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module cmp_ctrl_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cmp_raw = 1'b0;
    logic       adc_on = 1'b0;
    logic       irq_ack = 1'b0;
    logic       cmp_off, ref_sel, neg_from_mux, irq, cap_trig;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    cmp_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_raw(cmp_raw),
        .adc_on(adc_on), .irq_ack(irq_ack), .cmp_off(cmp_off), .ref_sel(ref_sel),
        .neg_from_mux(neg_from_mux), .irq(irq), .cap_trig(cap_trig)
    );

    // vector: mux_en, adc_on, cap_en, raw, exp_neg, exp_cap
    localparam logic [5:0] VEC [8] = '{
        6'b0_0_0_0_0_0, 6'b1_0_0_0_1_0, 6'b1_1_0_1_0_0, 6'b0_1_1_1_0_1,
        6'b1_0_1_1_1_1, 6'b1_1_1_0_0_0, 6'b0_0_1_0_0_0, 6'b1_0_0_1_1_0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(1'b0, r); chk("R1 main", r, 8'h00);
        rd(1'b1, r); chk("R1 aux", r, 8'h00);
        chk("R1 outs", {3'b0, cmp_off, ref_sel, neg_from_mux, irq, cap_trig}, 8'h00);

        // R9 / R10 table walk, mode 01 so no flag
        foreach (VEC[i]) begin
            wr(1'b1, {7'b0, VEC[i][5]});
            wr(1'b0, {5'b0, VEC[i][3], 2'b01});
            @(negedge clk);
            adc_on = VEC[i][4]; cmp_raw = VEC[i][2];
            settle(4);
            chk("R9 neg_from_mux", {7'b0, neg_from_mux}, {7'b0, VEC[i][1]});
            chk("R10 cap_trig", {7'b0, cap_trig}, {7'b0, VEC[i][0]});
        end
        wr(1'b1, 8'h00);
        adc_on = 1'b0;

        // R3 readback, bit5 write ignored, aux upper bits zero
        @(negedge clk); cmp_raw = 1'b0; settle(4);
        wr(1'b0, 8'h6D);  // off=0 ref=1 stat-write=1 flag-w=0 ie=1 cap=1 mode=01
        rd(1'b0, r); chk("R3 main readback", r, 8'h4D);
        chk("R11 ref_sel", {7'b0, ref_sel}, 8'h01);
        wr(1'b1, 8'hFF);
        rd(1'b1, r); chk("R3 aux readback", r, 8'h01);
        wr(1'b1, 8'h00);

        // R2 synchronizer latency
        wr(1'b0, 8'h01);
        @(negedge clk); cmp_raw = 1'b1;
        @(negedge clk); #1 chk("R2 after 1 edge", {7'b0, reg_rdata[5]}, 8'h00);
        @(negedge clk); #1 chk("R2 after 2 edges", {7'b0, reg_rdata[5]}, 8'h01);
        @(negedge clk); cmp_raw = 1'b0; settle(4);

        // R4 rising mode, with ie for R7
        wr(1'b0, 8'h0B);
        @(negedge clk); cmp_raw = 1'b1; settle(4);
        rd(1'b0, r); chk("R4 rise sets flag", {7'b0, r[4]}, 8'h01);
        chk("R7 irq high", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h03);
        chk("R7 irq low with ie=0", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h13);
        @(negedge clk); cmp_raw = 1'b0; settle(4);
        rd(1'b0, r); chk("R4 fall ignored in rise mode", {7'b0, r[4]}, 8'h00);

        // R4 falling mode
        wr(1'b0, 8'h02);
        @(negedge clk); cmp_raw = 1'b1; settle(4);
        rd(1'b0, r); chk("R4 rise ignored in fall mode", {7'b0, r[4]}, 8'h00);
        @(negedge clk); cmp_raw = 1'b0; settle(4);
        rd(1'b0, r); chk("R4 fall sets flag", {7'b0, r[4]}, 8'h01);

        // R6 writing 0 keeps flag, writing 1 clears
        wr(1'b0, 8'h02);
        rd(1'b0, r); chk("R6 write0 keeps flag", {7'b0, r[4]}, 8'h01);
        wr(1'b0, 8'h12);
        rd(1'b0, r); chk("R6 write1 clears", {7'b0, r[4]}, 8'h00);

        // R5 toggle mode, both edges; ack clears
        wr(1'b0, 8'h00);
        @(negedge clk); cmp_raw = 1'b1; settle(4);
        rd(1'b0, r); chk("R5 toggle rise", {7'b0, r[4]}, 8'h01);
        @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        rd(1'b0, r); chk("R6 ack clears", {7'b0, r[4]}, 8'h00);
        @(negedge clk); cmp_raw = 1'b0; settle(4);
        rd(1'b0, r); chk("R5 toggle fall", {7'b0, r[4]}, 8'h01);
        wr(1'b0, 8'h11);
        @(negedge clk); cmp_raw = 1'b1; settle(4);
        @(negedge clk); cmp_raw = 1'b0; settle(4);
        rd(1'b0, r); chk("R5 mode01 never sets", {7'b0, r[4]}, 8'h00);

        // R6 set wins over simultaneous ack: raw change at t, status after 2 edges, flag at 3rd
        wr(1'b0, 8'h03);
        @(negedge clk); cmp_raw = 1'b1;
        @(negedge clk); @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        rd(1'b0, r); chk("R6 set beats ack", {7'b0, r[4]}, 8'h01);
        wr(1'b0, 8'h13);

        // R8 power-down: status 0, no edges
        wr(1'b0, 8'h80);
        settle(2);
        rd(1'b0, r); chk("R8 status zero when off", {7'b0, r[5]}, 8'h00);
        chk("R8 cmp_off", {7'b0, cmp_off}, 8'h01);
        @(negedge clk); cmp_raw = 1'b0; settle(4);
        @(negedge clk); cmp_raw = 1'b1; settle(4);
        rd(1'b0, r); chk("R8 no flag when off", {7'b0, r[4]}, 8'h00);
        wr(1'b0, 8'h11); settle(4);
        wr(1'b0, 8'h11);
        rd(1'b0, r); chk("R8 status back after enable", r, 8'h21);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule